// File: doc/BRIEF.md
# I2C Line Watcher with Manual Clock Override

This block sits between an I2C master engine and the open-drain pads. It brings the raw SCL and SDA levels into the clock domain through a two-stage synchroniser, recognises START and STOP conditions on the synchronised lines, and keeps a bus-busy flag plus a sticky STOP-seen flag that software clears. The live synchronised line levels and the levels currently driven to the pads are visible on a four-bit monitor word.

The pad drives use an open-drain convention: 1 releases the line (pulled high externally) and 0 pulls it low. In normal operation the pads follow the engine's requests. A two-bit override register can take SCL away from the engine so software can toggle it by hand, for instance to clock a stuck target until it lets go of SDA. A forced controller reset clears bus-busy, releases both lines while it is held and puts the override back into normal operation.

Top module: `i2c_bus_watch`

## Requirements
- R1: After reset, bus_busy and stop_seen are 0, the override is in normal mode, and with both lines idle high and both engine requests 1 the monitor word reads 4'b1111.
- R2: Each raw line input reaches its monitor bit through exactly two clock registers: a change on the input appears after the second rising edge, not after the first.
- R3: A START (synchronised SDA falling while synchronised SCL is high) sets bus_busy one clock after detection; SDA falling while SCL is low leaves bus_busy unchanged.
- R4: A STOP (synchronised SDA rising while synchronised SCL is high) clears bus_busy and sets stop_seen; SDA rising while SCL is low sets neither. stop_seen stays 1 through later START conditions.
- R5: A one-cycle pulse on stop_clr clears stop_seen; when a STOP is detected in the same cycle as stop_clr, stop_seen ends up 1.
- R6: The override register (written with ovr_wr) holds a normal-mode bit in bit 1 and a clock-release bit in bit 0; its reset value is 2'b11. While bit 1 is 1, scl_out follows eng_scl and sda_out follows eng_sda.
- R7: While override bit 1 is 0, scl_out equals override bit 0 (1 released, 0 pulled low), sda_out is 1 (released), and the engine requests have no effect on either pad.
- R8: Writing 2'b11 to the override register returns both pads to engine control from the next cycle.
- R9: Monitor word bit positions: bit 3 is the driven SDA (sda_out), bit 2 the synchronised SDA, bit 1 the driven SCL (scl_out), bit 0 the synchronised SCL.
- R10: While force_rst is 1 both scl_out and sda_out are 1; on the clock edge where it is sampled, bus_busy clears and the override register returns to 2'b11. stop_seen is not affected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_in | input | 1 | Raw SCL pad level (asynchronous) |
| sda_in | input | 1 | Raw SDA pad level (asynchronous) |
| eng_scl | input | 1 | Engine SCL request, 1 release / 0 pull low |
| eng_sda | input | 1 | Engine SDA request, 1 release / 0 pull low |
| ovr_wr | input | 1 | Write strobe for the override register |
| ovr_wdata | input | 2 | Override write data: bit 1 normal mode, bit 0 SCL release |
| force_rst | input | 1 | Forced controller reset |
| stop_clr | input | 1 | Clears the sticky STOP-seen flag |
| scl_out | output | 1 | Final SCL pad drive, 1 release / 0 pull low |
| sda_out | output | 1 | Final SDA pad drive, 1 release / 0 pull low |
| bus_busy | output | 1 | Set by START, cleared by STOP or forced reset |
| stop_seen | output | 1 | Sticky STOP-detected flag |
| mon | output | 4 | Line monitor word (see R9) |

## Verification
SDA is moved both with SCL held low and with SCL held high, so a detector that ignores SCL, or that confuses data changes with bus conditions, marks busy or STOP on the wrong pattern. A STOP is timed to land in the same cycle as a clear pulse, which separates set-priority from clear-priority. The override is driven through release, pull-low and normal settings while the engine requests are moved against it, showing whether the engine leaks through and whether SDA is released in manual mode. A forced reset is applied while busy and in manual mode to show every part it must restore.

// File: rtl/i2c_bus_watch_pkg.sv
// Shared constants and types for the I2C line watcher.
// Assumes open-drain convention: 1 = release, 0 = pull low.
package i2c_bus_watch_pkg;

    localparam int LINE_COUNT = 2;   // SCL and SDA
    localparam int LINE_SCL   = 0;
    localparam int LINE_SDA   = 1;

    // Monitor word bit positions (observed by software)
    localparam int MON_SCL_SAMPLED = 0;
    localparam int MON_SCL_DRIVEN  = 1;
    localparam int MON_SDA_SAMPLED = 2;
    localparam int MON_SDA_DRIVEN  = 3;
    localparam int MON_WIDTH       = 4;

    // Override register: bit 1 normal mode, bit 0 SCL release
    typedef struct packed {
        logic normal;
        logic release_scl;
    } ovr_reg_t;

    localparam ovr_reg_t OVR_RESET = '{normal: 1'b1, release_scl: 1'b1};

endpackage

// File: rtl/i2c_bus_watch_sync.sv
// Multi-stage synchroniser for a group of asynchronous line inputs.
// Assumes lines idle high, so every stage resets to 1 to avoid a
// false edge when reset is released.
module i2c_bus_watch_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] raw_in,
    output logic [WIDTH-1:0] sync_out
);
    localparam int LAST = STAGES - 1;

    for (genvar g = 0; g < WIDTH; g++) begin : g_line
        logic [STAGES-1:0] chain;

        // Shift the raw level through the synchroniser chain
        always_ff @(posedge clk) begin
            if (!rst_n) chain <= '1;
            else        chain <= {chain[STAGES-2:0], raw_in[g]};
        end

        assign sync_out[g] = chain[LAST];
    end

endmodule

// File: rtl/i2c_bus_watch_cond.sv
// START/STOP detector with bus-busy and sticky STOP-seen flags.
// Assumes synchronised inputs; compares SDA against its previous
// sample while SCL is high.
module i2c_bus_watch_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    input  logic force_rst,
    input  logic stop_clr,
    output logic bus_busy,
    output logic stop_seen
);
    logic sda_prev;
    logic start_ev;
    logic stop_ev;

    // Remember last synchronised SDA for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) sda_prev <= 1'b1;
        else        sda_prev <= sda_s;
    end

    // Classify SDA edges with SCL high as bus conditions
    always_comb begin
        start_ev = scl_s &&  sda_prev && !sda_s;
        stop_ev  = scl_s && !sda_prev &&  sda_s;
    end

    // Bus busy: set by START, cleared by STOP or forced reset
    always_ff @(posedge clk) begin
        if (!rst_n || force_rst) bus_busy <= 1'b0;
        else if (stop_ev)        bus_busy <= 1'b0;
        else if (start_ev)       bus_busy <= 1'b1;
    end

    // Sticky STOP flag: set wins over clear
    always_ff @(posedge clk) begin
        if (!rst_n)        stop_seen <= 1'b0;
        else if (stop_ev)  stop_seen <= 1'b1;
        else if (stop_clr) stop_seen <= 1'b0;
    end

    AST_BUSY_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
        (start_ev && !force_rst) |=> bus_busy); // R3
    AST_IDLE_ON_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        stop_ev |=> (!bus_busy && stop_seen)); // R4
    AST_STOP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_seen && !stop_clr) |=> stop_seen); // R5
    AST_FORCE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        force_rst |=> !bus_busy); // R10

endmodule

// File: rtl/i2c_bus_watch_drive.sv
// Override register and pad-drive selector.
// Assumes open-drain pads: 1 releases the line, 0 pulls it low.
module i2c_bus_watch_drive
    import i2c_bus_watch_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ovr_wr,
    input  logic [1:0] ovr_wdata,
    input  logic       force_rst,
    input  logic       eng_scl,
    input  logic       eng_sda,
    output logic       scl_out,
    output logic       sda_out
);
    ovr_reg_t ovr_q;

    // Override register: forced reset returns it to normal mode
    always_ff @(posedge clk) begin
        if (!rst_n || force_rst) ovr_q <= OVR_RESET;
        else if (ovr_wr)         ovr_q <= ovr_reg_t'(ovr_wdata);
    end

    // Select pad drives: forced release, engine, or manual SCL
    always_comb begin
        if (force_rst) begin
            scl_out = 1'b1;
            sda_out = 1'b1;
        end else if (ovr_q.normal) begin
            scl_out = eng_scl;
            sda_out = eng_sda;
        end else begin
            scl_out = ovr_q.release_scl;
            sda_out = 1'b1;
        end
    end

    AST_MANUAL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_wr && ovr_wdata == 2'b00 && !force_rst) |=> (force_rst || !scl_out)); // R7
    AST_MANUAL_SDA: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_wr && !ovr_wdata[1] && !force_rst) |=> sda_out); // R7
    AST_NORMAL_AFTER_FORCE: assert property (@(posedge clk) disable iff (!rst_n)
        (force_rst && !ovr_wr) |=> (force_rst || (scl_out == eng_scl && sda_out == eng_sda))); // R10

endmodule

// File: rtl/i2c_bus_watch.sv
// I2C line watcher: synchronises the pad levels, tracks bus state and
// drives the pads from the engine or from a manual SCL override.
// Assumes asynchronous pad inputs and open-drain pad drives.
module i2c_bus_watch
    import i2c_bus_watch_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 scl_in,
    input  logic                 sda_in,
    input  logic                 eng_scl,
    input  logic                 eng_sda,
    input  logic                 ovr_wr,
    input  logic [1:0]           ovr_wdata,
    input  logic                 force_rst,
    input  logic                 stop_clr,
    output logic                 scl_out,
    output logic                 sda_out,
    output logic                 bus_busy,
    output logic                 stop_seen,
    output logic [MON_WIDTH-1:0] mon
);
    logic [LINE_COUNT-1:0] raw_lines;
    logic [LINE_COUNT-1:0] sync_lines;

    assign raw_lines[LINE_SCL] = scl_in;
    assign raw_lines[LINE_SDA] = sda_in;

    i2c_bus_watch_sync #(
        .WIDTH  (LINE_COUNT),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .raw_in   (raw_lines),
        .sync_out (sync_lines)
    );

    i2c_bus_watch_cond u_cond (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_s     (sync_lines[LINE_SCL]),
        .sda_s     (sync_lines[LINE_SDA]),
        .force_rst (force_rst),
        .stop_clr  (stop_clr),
        .bus_busy  (bus_busy),
        .stop_seen (stop_seen)
    );

    i2c_bus_watch_drive u_drive (
        .clk       (clk),
        .rst_n     (rst_n),
        .ovr_wr    (ovr_wr),
        .ovr_wdata (ovr_wdata),
        .force_rst (force_rst),
        .eng_scl   (eng_scl),
        .eng_sda   (eng_sda),
        .scl_out   (scl_out),
        .sda_out   (sda_out)
    );

    // Assemble the monitor word from live and driven levels
    always_comb begin
        mon                  = '0;
        mon[MON_SCL_SAMPLED] = sync_lines[LINE_SCL];
        mon[MON_SCL_DRIVEN]  = scl_out;
        mon[MON_SDA_SAMPLED] = sync_lines[LINE_SDA];
        mon[MON_SDA_DRIVEN]  = sda_out;
    end

    AST_FORCE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        force_rst |-> (mon[MON_SCL_DRIVEN] && mon[MON_SDA_DRIVEN])); // R10
    AST_RESTORE_ENGINE: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_wr && ovr_wdata == 2'b11 && !force_rst) |=> (scl_out == eng_scl)); // R8

endmodule

// File: tb/i2c_bus_watch_bench.sv
module i2c_bus_watch_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_in = 1'b1, sda_in = 1'b1;
    logic       eng_scl = 1'b1, eng_sda = 1'b1;
    logic       ovr_wr = 1'b0;
    logic [1:0] ovr_wdata = 2'b11;
    logic       force_rst = 1'b0, stop_clr = 1'b0;
    logic       scl_out, sda_out, bus_busy, stop_seen;
    logic [3:0] mon;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    i2c_bus_watch u_i2c_bus_watch (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
        .eng_scl(eng_scl), .eng_sda(eng_sda), .ovr_wr(ovr_wr),
        .ovr_wdata(ovr_wdata), .force_rst(force_rst), .stop_clr(stop_clr),
        .scl_out(scl_out), .sda_out(sda_out), .bus_busy(bus_busy),
        .stop_seen(stop_seen), .mon(mon)
    );

    task automatic check(input string req, input string what,
                         input logic [3:0] act, input logic [3:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    // Advance n rising edges, then settle at the falling edge
    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic write_ovr(input logic [1:0] v);
        ovr_wr = 1'b1; ovr_wdata = v;
        tick(1);
        ovr_wr = 1'b0;
    endtask

    task automatic t_reset;
        check("R1", "busy", {3'b0, bus_busy}, 4'd0);
        check("R1", "stop_seen", {3'b0, stop_seen}, 4'd0);
        check("R1", "monitor", mon, 4'b1111);
    endtask

    task automatic t_sync_and_map;
        scl_in = 1'b0;
        tick(1);
        check("R2", "scl sampled after 1 edge", {3'b0, mon[0]}, 4'd1);
        tick(1);
        check("R2", "scl sampled after 2 edges", {3'b0, mon[0]}, 4'd0);
        sda_in = 1'b0; eng_sda = 1'b0;
        tick(2);
        check("R9", "monitor map sda low", mon, 4'b0010);
        eng_sda = 1'b1; eng_scl = 1'b0;
        tick(0);
        check("R9", "monitor map driven scl low", mon, 4'b1000);
        eng_scl = 1'b1; sda_in = 1'b1;
        tick(3);
    endtask

    task automatic t_start;
        // scl low here; sda falls as data: no START
        sda_in = 1'b0; tick(3);
        check("R3", "sda fall with scl low", {3'b0, bus_busy}, 4'd0);
        sda_in = 1'b1; tick(3);
        check("R4", "sda rise with scl low", {3'b0, stop_seen}, 4'd0);
        scl_in = 1'b1; tick(3);
        sda_in = 1'b0; tick(3);
        check("R3", "start sets busy", {3'b0, bus_busy}, 4'd1);
    endtask

    task automatic t_stop;
        sda_in = 1'b1; tick(3);
        check("R4", "stop clears busy", {3'b0, bus_busy}, 4'd0);
        check("R4", "stop sets flag", {3'b0, stop_seen}, 4'd1);
        sda_in = 1'b0; tick(3);
        check("R3", "second start busy", {3'b0, bus_busy}, 4'd1);
        check("R4", "flag sticky through start", {3'b0, stop_seen}, 4'd1);
    endtask

    task automatic t_clear;
        stop_clr = 1'b1; tick(1); stop_clr = 1'b0;
        check("R5", "clear pulse", {3'b0, stop_seen}, 4'd0);
        // STOP detection lands between the 2nd and 3rd edge after the change
        sda_in = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        stop_clr = 1'b1;
        tick(1);
        stop_clr = 1'b0;
        check("R5", "stop wins over clear", {3'b0, stop_seen}, 4'd1);
        check("R4", "busy after collision stop", {3'b0, bus_busy}, 4'd0);
    endtask

    task automatic t_override;
        eng_scl = 1'b0; tick(0);
        check("R6", "normal follows engine scl", {3'b0, scl_out}, 4'd0);
        write_ovr(2'b00);
        eng_scl = 1'b1; eng_sda = 1'b0; tick(0);
        check("R7", "manual scl low", {3'b0, scl_out}, 4'd0);
        check("R7", "manual sda released", {3'b0, sda_out}, 4'd1);
        write_ovr(2'b01);
        eng_scl = 1'b0; tick(0);
        check("R7", "manual scl released", {3'b0, scl_out}, 4'd1);
        check("R9", "driven scl in monitor", {3'b0, mon[1]}, 4'd1);
        write_ovr(2'b11);
        check("R8", "engine control back", {2'b0, scl_out, sda_out}, 4'b0000);
        eng_scl = 1'b1; eng_sda = 1'b1; tick(0);
    endtask

    task automatic t_force;
        sda_in = 1'b0; tick(3);  // START, scl high
        check("R3", "busy before force", {3'b0, bus_busy}, 4'd1);
        write_ovr(2'b00);
        eng_scl = 1'b0; eng_sda = 1'b0;
        force_rst = 1'b1; tick(0);
        check("R10", "lines released during force", {2'b0, scl_out, sda_out}, 4'b0011);
        tick(1);
        force_rst = 1'b0; tick(0);
        check("R10", "busy cleared", {3'b0, bus_busy}, 4'd0);
        check("R10", "override normal again", {2'b0, scl_out, sda_out}, 4'b0000);
        check("R10", "stop flag kept", {3'b0, stop_seen}, 4'd1);
    endtask

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        t_reset();
        t_sync_and_map();
        t_start();
        t_stop();
        t_clear();
        t_override();
        t_force();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule